// File: doc/BRIEF.md
# Register Window Control Unit

This block holds the bookkeeping state of a windowed integer register file: the current window pointer and the counters that say how many windows may still be saved, how many may be restored, how many are clean, and how many belong to another address space. A separate 6-bit field holds two 3-bit trap type selectors. When the pipeline issues a window operation (save, restore or flush), the unit decides in one step whether the operation completes normally or traps, updates the pointer and counters, and reports the trap kind together with the 3-bit type taken from the selector field.

Supervisor code loads any of the state fields through a simple write port. The register file itself and the vectoring of the trap to a handler live elsewhere; this unit only produces the decision and the new state.

Top module: `regwin_ctrl`

## Requirements
- R1: A save (op_code 1) with cansave equal to 0 raises a spill trap (trap_code 1), advances cwp by 2 modulo NWIN and leaves all counters unchanged.
- R2: For spill and fill traps, trap_type is wstate[5:3] when otherwin is nonzero and wstate[2:0] when otherwin is zero; for a clean-window trap or no trap, trap_type is 0.
- R3: A save with cansave nonzero and cleanwin equal to canrestore advances cwp by 1 modulo NWIN, raises a clean-window trap (trap_code 3) and leaves the counters unchanged.
- R4: Any other save advances cwp by 1 modulo NWIN, decrements cansave, increments canrestore and raises no trap.
- R5: A restore (op_code 2) moves cwp back by 1 modulo NWIN whether or not it traps.
- R6: A restore with canrestore equal to 0 raises a fill trap (trap_code 2) with counters unchanged; otherwise it increments cansave, decrements canrestore and raises no trap.
- R7: A flush (op_code 3) raises a spill trap when cansave differs from NWIN-2 and no trap otherwise; it never changes cwp or any counter.
- R8: Results of an operation sampled at a rising edge appear on the outputs right after that edge; trap_valid is high for exactly one cycle per trapping operation, and trap_code and trap_type are 0 whenever trap_valid is low.
- R9: With op_valid low and wr_en high, wr_data is loaded into the field chosen by wr_sel (0 cwp, 1 cansave, 2 canrestore, 3 cleanwin, 4 otherwin, 5 wstate; counters take the low CW bits; 6 and 7 change nothing). A write presented in the same cycle as op_valid is discarded.
- R10: After reset, cwp, canrestore, otherwin and wstate are 0, cansave is NWIN-2, cleanwin is NWIN-1, and no trap is reported.
- R11: op_valid with op_code 0 changes no state and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Window operation strobe |
| op_code | input | 2 | 0 none, 1 save, 2 restore, 3 flush |
| wr_en | input | 1 | State field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 6 | Write data |
| cwp | output | CW (3) | Current window pointer |
| cansave | output | CW (3) | Windows available to save |
| canrestore | output | CW (3) | Windows available to restore |
| cleanwin | output | CW (3) | Clean window count |
| otherwin | output | CW (3) | Windows owned by another space |
| wstate | output | 6 | Two 3-bit trap type selectors |
| trap_valid | output | 1 | One-cycle trap indication |
| trap_code | output | 2 | 0 none, 1 spill, 2 fill, 3 clean window |
| trap_type | output | 3 | Selected trap type |

## Verification
Every result, state or trap, is due exactly one rising edge after the operation or write is sampled, since the decision is combinational and lands in a single register stage. The bench drives inputs on the falling edge, advances its own model at the same moment, and compares the full output vector on the following falling edge, so every cycle is checked including idle ones where trap_valid must have dropped. Reset release passes a two-flop synchronizer, so the reset check waits several cycles after rst_n rises.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int WST_W  = 6;
  localparam int TTYP_W = 3;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_SAVE    = 2'd1,
    OP_RESTORE = 2'd2,
    OP_FLUSHW  = 2'd3
  } rw_op_e;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_SPILL = 2'd1,
    TRAP_FILL  = 2'd2,
    TRAP_CLEAN = 2'd3
  } rw_trap_e;

  typedef enum logic [2:0] {
    SEL_CWP    = 3'd0,
    SEL_CANSV  = 3'd1,
    SEL_CANRS  = 3'd2,
    SEL_CLEAN  = 3'd3,
    SEL_OTHER  = 3'd4,
    SEL_WSTATE = 3'd5
  } rw_sel_e;
endpackage

// File: rtl/regwin_wrap.sv
module regwin_wrap #(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic [CW-1:0] cur,
  output logic [CW-1:0] plus1,
  output logic [CW-1:0] plus2,
  output logic [CW-1:0] minus1
);
  localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

  generate
    if (POW2) begin : g_pow2
      always_comb begin
        plus1  = cur + CW'(1);
        plus2  = cur + CW'(2);
        minus1 = cur - CW'(1);
      end
    end else begin : g_general
      logic [CW:0] s1, s2;
      always_comb begin
        s1     = {1'b0, cur} + (CW+1)'(1);
        s2     = {1'b0, cur} + (CW+1)'(2);
        plus1  = (s1 >= (CW+1)'(NWIN)) ? CW'(s1 - (CW+1)'(NWIN)) : s1[CW-1:0];
        plus2  = (s2 >= (CW+1)'(NWIN)) ? CW'(s2 - (CW+1)'(NWIN)) : s2[CW-1:0];
        minus1 = (cur == '0) ? CW'(NWIN - 1) : cur - CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/regwin_decide.sv
module regwin_decide
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic              op_valid,
  input  logic [1:0]        op,
  input  logic [CW-1:0]     cwp,
  input  logic [CW-1:0]     cansave,
  input  logic [CW-1:0]     canrestore,
  input  logic [CW-1:0]     cleanwin,
  input  logic [CW-1:0]     otherwin,
  input  logic [WST_W-1:0]  wstate,
  input  logic [CW-1:0]     cwp_p1,
  input  logic [CW-1:0]     cwp_p2,
  input  logic [CW-1:0]     cwp_m1,
  output logic [CW-1:0]     n_cwp,
  output logic [CW-1:0]     n_cansave,
  output logic [CW-1:0]     n_canrestore,
  output rw_trap_e          trap,
  output logic [TTYP_W-1:0] ttype
);
  localparam logic [CW-1:0] FLUSH_DONE = CW'(NWIN - 2);

  logic [TTYP_W-1:0] sel_type;

  always_comb begin
    n_cwp        = cwp;
    n_cansave    = cansave;
    n_canrestore = canrestore;
    trap         = TRAP_NONE;
    sel_type     = (otherwin != '0) ? wstate[5:3] : wstate[2:0];
    if (op_valid) begin
      case (rw_op_e'(op))
        OP_SAVE: begin
          if (cansave == '0) begin
            trap  = TRAP_SPILL;
            n_cwp = cwp_p2;
          end else if (cleanwin == canrestore) begin
            trap  = TRAP_CLEAN;
            n_cwp = cwp_p1;
          end else begin
            n_cwp        = cwp_p1;
            n_cansave    = cansave - CW'(1);
            n_canrestore = canrestore + CW'(1);
          end
        end
        OP_RESTORE: begin
          n_cwp = cwp_m1;
          if (canrestore == '0) begin
            trap = TRAP_FILL;
          end else begin
            n_cansave    = cansave + CW'(1);
            n_canrestore = canrestore - CW'(1);
          end
        end
        OP_FLUSHW: begin
          if (cansave != FLUSH_DONE) trap = TRAP_SPILL;
        end
        default: ;
      endcase
    end
    ttype = ((trap == TRAP_SPILL) || (trap == TRAP_FILL)) ? sel_type : '0;
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WST_W-1:0]  wr_data,
  output logic [CW-1:0]     cwp,
  output logic [CW-1:0]     cansave,
  output logic [CW-1:0]     canrestore,
  output logic [CW-1:0]     cleanwin,
  output logic [CW-1:0]     otherwin,
  output logic [WST_W-1:0]  wstate,
  output logic              trap_valid,
  output logic [1:0]        trap_code,
  output logic [TTYP_W-1:0] trap_type
);
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [CW-1:0]     cwp_p1, cwp_p2, cwp_m1;
  logic [CW-1:0]     dec_cwp, dec_cs, dec_cr;
  rw_trap_e          dec_trap;
  logic [TTYP_W-1:0] dec_type;

  regwin_wrap #(.NWIN(NWIN), .CW(CW)) u_wrap (
    .cur(cwp), .plus1(cwp_p1), .plus2(cwp_p2), .minus1(cwp_m1)
  );

  regwin_decide #(.NWIN(NWIN), .CW(CW)) u_decide (
    .op_valid(op_valid), .op(op_code), .cwp(cwp), .cansave(cansave),
    .canrestore(canrestore), .cleanwin(cleanwin), .otherwin(otherwin),
    .wstate(wstate), .cwp_p1(cwp_p1), .cwp_p2(cwp_p2), .cwp_m1(cwp_m1),
    .n_cwp(dec_cwp), .n_cansave(dec_cs), .n_canrestore(dec_cr),
    .trap(dec_trap), .ttype(dec_type)
  );

  logic [CW-1:0]    cwp_d, cs_d, cr_d, cw_d, ow_d;
  logic [WST_W-1:0] ws_d;
  logic             state_en;

  assign state_en = op_valid | wr_en;

  always_comb begin
    cwp_d = dec_cwp;
    cs_d  = dec_cs;
    cr_d  = dec_cr;
    cw_d  = cleanwin;
    ow_d  = otherwin;
    ws_d  = wstate;
    if (!op_valid && wr_en) begin
      case (rw_sel_e'(wr_sel))
        SEL_CWP:    cwp_d = wr_data[CW-1:0];
        SEL_CANSV:  cs_d  = wr_data[CW-1:0];
        SEL_CANRS:  cr_d  = wr_data[CW-1:0];
        SEL_CLEAN:  cw_d  = wr_data[CW-1:0];
        SEL_OTHER:  ow_d  = wr_data[CW-1:0];
        SEL_WSTATE: ws_d  = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cwp        <= '0;
      cansave    <= CW'(NWIN - 2);
      canrestore <= '0;
      cleanwin   <= CW'(NWIN - 1);
      otherwin   <= '0;
      wstate     <= '0;
    end else if (state_en) begin
      cwp        <= cwp_d;
      cansave    <= cs_d;
      canrestore <= cr_d;
      cleanwin   <= cw_d;
      otherwin   <= ow_d;
      wstate     <= ws_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      trap_valid <= 1'b0;
      trap_code  <= TRAP_NONE;
      trap_type  <= '0;
    end else begin
      trap_valid <= op_valid && (dec_trap != TRAP_NONE);
      trap_code  <= dec_trap;
      trap_type  <= dec_type;
    end
  end

  AST_SAVE_SPILL: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_SAVE && cansave == '0) |=> (trap_valid && trap_code == TRAP_SPILL)); // R1
  AST_OTHER_TYPE: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_SAVE && cansave == '0 && otherwin != '0) |=> (trap_type == $past(wstate[5:3]))); // R2
  AST_SAVE_COUNTS: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_SAVE && cansave != '0 && cleanwin != canrestore)
    |=> (cansave == $past(cansave) - CW'(1) && canrestore == $past(canrestore) + CW'(1) && !trap_valid)); // R4
  AST_RESTORE_BACK: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_RESTORE)
    |=> (cwp == (($past(cwp) == '0) ? CW'(NWIN - 1) : $past(cwp) - CW'(1)))); // R5
  AST_RESTORE_FILL: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_RESTORE && canrestore == '0) |=> (trap_code == TRAP_FILL && trap_valid)); // R6
  AST_FLUSH_STILL: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && op_code == OP_FLUSHW) |=> ($stable(cwp) && $stable(cansave) && $stable(canrestore))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (!op_valid) |=> (!trap_valid && trap_code == TRAP_NONE && trap_type == '0)); // R8
endmodule

// File: tb/regwin_ctrl_bench.sv
module regwin_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;
  localparam int CW   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid;
  logic [1:0] op_code;
  logic wr_en;
  logic [2:0] wr_sel;
  logic [5:0] wr_data;
  logic [CW-1:0] cwp, cansave, canrestore, cleanwin, otherwin;
  logic [5:0] wstate;
  logic trap_valid;
  logic [1:0] trap_code;
  logic [2:0] trap_type;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_ctrl #(.NWIN(NWIN), .CW(CW)) u_regwin_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate),
    .trap_valid(trap_valid), .trap_code(trap_code), .trap_type(trap_type)
  );

  int total = 0;
  int bad   = 0;

  logic [CW-1:0] m_cwp, m_cs, m_cr, m_cw, m_ow;
  logic [5:0]    m_ws;
  logic          e_tv;
  logic [1:0]    e_tc;
  logic [2:0]    e_tt;

  function automatic logic [26:0] pack_exp();
    return {m_cwp, m_cs, m_cr, m_cw, m_ow, m_ws, e_tv, e_tc, e_tt};
  endfunction

  function automatic logic [26:0] pack_act();
    return {cwp, cansave, canrestore, cleanwin, otherwin, wstate, trap_valid, trap_code, trap_type};
  endfunction

  task automatic check(input string tag);
    total++;
    if (pack_act() !== pack_exp()) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, pack_act(), pack_exp());
    end
  endtask

  function automatic logic [CW-1:0] wrap(input int v);
    return CW'(((v % NWIN) + NWIN) % NWIN);
  endfunction

  // Drive one cycle at a falling edge, advance the model, check at next falling edge.
  task automatic step(input logic v, input logic [1:0] op, input logic we,
                      input logic [2:0] sel, input logic [5:0] data);
    string tag;
    logic [2:0] styp;
    op_valid = v; op_code = op; wr_en = we; wr_sel = sel; wr_data = data;
    tag  = "R8";
    e_tc = 2'd0;
    e_tt = 3'd0;
    styp = (m_ow != 0) ? m_ws[5:3] : m_ws[2:0];
    if (v) begin
      case (op)
        2'd1: begin
          if (m_cs == 0) begin
            e_tc = 2'd1; e_tt = styp; m_cwp = wrap(int'(m_cwp) + 2);
            tag = (m_ow != 0) ? "R2" : "R1";
          end else if (m_cw == m_cr) begin
            e_tc = 2'd3; m_cwp = wrap(int'(m_cwp) + 1); tag = "R3";
          end else begin
            m_cwp = wrap(int'(m_cwp) + 1); m_cs = m_cs - 1; m_cr = m_cr + 1; tag = "R4";
          end
        end
        2'd2: begin
          m_cwp = wrap(int'(m_cwp) - 1);
          if (m_cr == 0) begin
            e_tc = 2'd2; e_tt = styp; tag = "R6";
          end else begin
            m_cs = m_cs + 1; m_cr = m_cr - 1; tag = "R5";
          end
        end
        2'd3: begin
          tag = "R7";
          if (int'(m_cs) != NWIN - 2) begin
            e_tc = 2'd1; e_tt = styp;
          end
        end
        default: tag = "R11";
      endcase
      if (we) tag = "R9";
    end else if (we) begin
      tag = "R9";
      case (sel)
        3'd0: m_cwp = data[CW-1:0];
        3'd1: m_cs  = data[CW-1:0];
        3'd2: m_cr  = data[CW-1:0];
        3'd3: m_cw  = data[CW-1:0];
        3'd4: m_ow  = data[CW-1:0];
        3'd5: m_ws  = data;
        default: ;
      endcase
    end
    e_tv = (e_tc != 2'd0);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'd0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 6'd0;
    m_cwp = 0; m_cs = CW'(NWIN - 2); m_cr = 0; m_cw = CW'(NWIN - 1); m_ow = 0; m_ws = 0;
    e_tv = 0; e_tc = 0; e_tt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10");

    // directed corners
    step(0, 0, 1, 3'd5, 6'b101_011);   // R9 wstate
    step(0, 0, 1, 3'd1, 6'd0);         // R9 cansave=0
    step(1, 1, 0, 0, 0);               // R1 spill, type 3, cwp 2
    step(0, 0, 0, 0, 0);               // R8 trap drops
    step(0, 0, 1, 3'd4, 6'd1);         // otherwin=1
    step(1, 1, 0, 0, 0);               // R2 type 5, cwp 4
    step(0, 0, 1, 3'd1, 6'd3);
    step(0, 0, 1, 3'd3, 6'd2);
    step(0, 0, 1, 3'd2, 6'd2);
    step(1, 1, 0, 0, 0);               // R3 clean
    step(0, 0, 1, 3'd3, 6'd7);
    step(1, 1, 0, 0, 0);               // R4 normal
    step(1, 1, 0, 0, 0);               // R4 cwp 7
    step(1, 1, 0, 0, 0);               // R4 cwp wraps to 0
    step(1, 2, 0, 0, 0);               // R5 cwp 0 -> 7
    step(0, 0, 1, 3'd2, 6'd0);
    step(1, 2, 0, 0, 0);               // R6 fill
    step(0, 0, 1, 3'd4, 6'd0);
    step(1, 2, 0, 0, 0);               // R6 fill with low type
    step(1, 3, 0, 0, 0);               // R7 spill on flush
    step(0, 0, 1, 3'd1, 6'd6);
    step(1, 3, 0, 0, 0);               // R7 no trap
    step(1, 0, 1, 3'd0, 6'd5);         // R9 write ignored, R11
    step(1, 0, 0, 0, 0);               // R11
    step(0, 0, 1, 3'd6, 6'd63);        // R9 unused selector
    step(0, 0, 1, 3'd7, 6'd63);        // R9 unused selector

    for (int i = 0; i < 4000; i++) begin
      logic v, we;
      v  = ($urandom % 10) < 6;
      we = ($urandom % 10) < 4;
      step(v, 2'($urandom % 4), we, 3'($urandom % 8), 6'($urandom % 64));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule